// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits on the CPU side of the interrupt path. When the interrupt controller accepts a request, the block takes a strobe and a source index. It captures the restart address and the current status word in the same cycle, then runs a fixed five-step context save, one step per clock. The steps are:

1. Write the restart address to the saved-address register.
2. Write the status word to the saved-status register.
3. Write a cause code into the low half of the cause register.
4. Rewrite the status word with interrupts disabled and the exception-pending flag cleared.
5. Redirect the fetch to the source's handler address.

The registers themselves live outside the block. The block drives their write strobes and data.

A return strobe restores the context in a single cycle. In that cycle the block redirects the fetch to the saved address and rewrites the status word from the saved-status value. It also pulses an end-of-interrupt line to the controller. Once the restored status word clears the disable bits, the controller may take pending requests again.

The cause code is 0x0080 + 16 × source index. The handler address is `VEC_BASE` + 16 × source index. In the 32-bit status word, bit 5 is the interrupt-disable flag, bit 6 is the exception-pending flag and bit 7 is the non-maskable-in-service flag.

Top module: `intr_ctx_seq`

## Requirements
- R1: During and after reset, with no strobe applied, every write strobe, `redir_o`, `eoi_o` and `busy_o` are 0.
- R2: An accept (`take_i`=1 while `busy_o`=0 and `ret_i`=0) raises `busy_o` in the five following cycles and drops it in the sixth.
- R3: In the first cycle after an accept, `spc_we_o`=1 and `spc_o` equals the `rpc_i` value sampled at the accept, whatever `rpc_i` does afterwards.
- R4: In the second cycle, `spsw_we_o`=1 and `spsw_o` equals the `psw_i` value sampled at the accept.
- R5: In the third cycle, `cause_we_o`=1 and the 16-bit `cause_o` equals 0x0080 + 16 × the accepted source index. The write covers the low half of the cause register only.
- R6: In the fourth cycle, `psw_we_o`=1 and `psw_o` equals the captured status word with bit 5 set and bit 6 cleared. All other bits, bit 7 included, are unchanged.
- R7: In the fifth cycle, `redir_o`=1 and `pc_o` equals `VEC_BASE` + 16 × the accepted source index.
- R8: During entry, exactly one of {`spc_we_o`, `spsw_we_o`, `cause_we_o`, `psw_we_o`, `redir_o`} is 1 per cycle, in that order.
- R9: `take_i` while `busy_o`=1 is ignored: the running sequence keeps its source and data, and no new sequence follows.
- R10: `ret_i` while idle gives, in the next cycle, `redir_o`=1 with `pc_o`=`spc_i`, `psw_we_o`=1 with `psw_o`=`spsw_i` (both as sampled with the strobe), and `eoi_o`=1 with `busy_o`=1. All of these are 0 in the cycle after.
- R11: `ret_i` while `busy_o`=1 is ignored: no `eoi_o` and no extra redirect.
- R12: When `ret_i` and `take_i` are both 1 in an idle cycle, the return is performed and the accept is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Interrupt accepted strobe |
| src_i | input | SRC_W | Accepted source index |
| rpc_i | input | 32 | Restart address |
| psw_i | input | 32 | Current status word |
| ret_i | input | 1 | Return-from-interrupt strobe |
| spc_i | input | 32 | Saved-address register contents |
| spsw_i | input | 32 | Saved-status register contents |
| busy_o | output | 1 | Sequence or return in progress |
| spc_we_o | output | 1 | Saved-address write enable |
| spc_o | output | 32 | Saved-address write data |
| spsw_we_o | output | 1 | Saved-status write enable |
| spsw_o | output | 32 | Saved-status write data |
| cause_we_o | output | 1 | Cause low-half write enable |
| cause_o | output | 16 | Cause low-half write data |
| psw_we_o | output | 1 | Status word write enable |
| psw_o | output | 32 | Status word write data |
| redir_o | output | 1 | Fetch redirect |
| pc_o | output | 32 | Redirect target |
| eoi_o | output | 1 | End-of-interrupt pulse |

## Verification
The bench changes `rpc_i`, `psw_i`, `src_i` and `spc_i` right after each strobe. A design that saved live inputs instead of the captured values would then write the wrong context. Status words with bit 6 set, bit 5 clear and bit 7 set check the flag rewrite. A design that cleared the wrong flag or zeroed bit 7 would show a wrong `psw_o`. Accept and return strobes are driven in the middle of a sequence, and both strobes together in an idle cycle. A design without the busy guard would restart, corrupt the cause code or pulse `eoi_o` early. A design with the wrong priority would enter a handler instead of returning. Source index 0 and the largest index check the cause and vector arithmetic at both ends.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SPC   = 3'd1,
        ST_SPSW  = 3'd2,
        ST_CAUSE = 3'd3,
        ST_FLAG  = 3'd4,
        ST_JUMP  = 3'd5,
        ST_RET   = 3'd6
    } seq_st_e;

    localparam int          XLEN       = 32;
    localparam int          ID_BIT     = 5;
    localparam int          EP_BIT     = 6;
    localparam int          NP_BIT     = 7;
    localparam logic [15:0] CAUSE_BASE = 16'h0080;
    localparam int          VEC_SHIFT  = 4;

    // Status word rewrite on entry: disable interrupts, clear exception pending.
    function automatic logic [XLEN-1:0] entry_psw(input logic [XLEN-1:0] w);
        logic [XLEN-1:0] r;
        r         = w;
        r[ID_BIT] = 1'b1;
        r[EP_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/intr_vec_map.sv
module intr_vec_map #(
    parameter int          SRC_W    = 6,
    parameter logic [31:0] VEC_BASE = 32'h0000_1000
) (
    input  logic [SRC_W-1:0] src_i,
    output logic [15:0]      cause_o,
    output logic [31:0]      handler_o
);
    import intr_seq_pkg::*;

    localparam int OFS_W = SRC_W + VEC_SHIFT;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs       = {src_i, {VEC_SHIFT{1'b0}}};
        cause_o   = CAUSE_BASE + 16'(ofs);
        handler_o = VEC_BASE + 32'(ofs);
    end

endmodule

// File: rtl/intr_step_fsm.sv
module intr_step_fsm #(
    parameter int SRC_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_i,
    input  logic                          ret_i,
    input  logic [SRC_W-1:0]              src_i,
    input  logic [31:0]                   rpc_i,
    input  logic [31:0]                   psw_i,
    input  logic [31:0]                   spc_i,
    input  logic [31:0]                   spsw_i,
    output intr_seq_pkg::seq_st_e         st_o,
    output logic [SRC_W-1:0]              src_o,
    output logic [31:0]                   addr_o,
    output logic [31:0]                   word_o
);
    import intr_seq_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        logic [SRC_W-1:0] src;
        logic [31:0]      addr;
        logic [31:0]      word;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (ret_i) begin
                    fsm_d.st   = ST_RET;
                    fsm_d.addr = spc_i;
                    fsm_d.word = spsw_i;
                end else if (take_i) begin
                    fsm_d.st   = ST_SPC;
                    fsm_d.src  = src_i;
                    fsm_d.addr = rpc_i;
                    fsm_d.word = psw_i;
                end
            end
            ST_SPC:   fsm_d.st = ST_SPSW;
            ST_SPSW:  fsm_d.st = ST_CAUSE;
            ST_CAUSE: fsm_d.st = ST_FLAG;
            ST_FLAG:  fsm_d.st = ST_JUMP;
            ST_JUMP:  fsm_d.st = ST_IDLE;
            ST_RET:   fsm_d.st = ST_IDLE;
            default:  fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, default: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st_o   = fsm_q.st;
    assign src_o  = fsm_q.src;
    assign addr_o = fsm_q.addr;
    assign word_o = fsm_q.word;

endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq #(
    parameter int          SRC_W    = 6,
    parameter logic [31:0] VEC_BASE = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [31:0]      rpc_i,
    input  logic [31:0]      psw_i,
    input  logic             ret_i,
    input  logic [31:0]      spc_i,
    input  logic [31:0]      spsw_i,
    output logic             busy_o,
    output logic             spc_we_o,
    output logic [31:0]      spc_o,
    output logic             spsw_we_o,
    output logic [31:0]      spsw_o,
    output logic             cause_we_o,
    output logic [15:0]      cause_o,
    output logic             psw_we_o,
    output logic [31:0]      psw_o,
    output logic             redir_o,
    output logic [31:0]      pc_o,
    output logic             eoi_o
);
    import intr_seq_pkg::*;

    seq_st_e          st;
    logic [SRC_W-1:0] src_q;
    logic [31:0]      addr_q;
    logic [31:0]      word_q;
    logic [15:0]      cause_w;
    logic [31:0]      handler_w;

    intr_step_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_i),
        .ret_i  (ret_i),
        .src_i  (src_i),
        .rpc_i  (rpc_i),
        .psw_i  (psw_i),
        .spc_i  (spc_i),
        .spsw_i (spsw_i),
        .st_o   (st),
        .src_o  (src_q),
        .addr_o (addr_q),
        .word_o (word_q)
    );

    intr_vec_map #(.SRC_W(SRC_W), .VEC_BASE(VEC_BASE)) u_map (
        .src_i     (src_q),
        .cause_o   (cause_w),
        .handler_o (handler_w)
    );

    always_comb begin
        busy_o     = (st != ST_IDLE);
        spc_we_o   = (st == ST_SPC);
        spsw_we_o  = (st == ST_SPSW);
        cause_we_o = (st == ST_CAUSE);
        psw_we_o   = (st == ST_FLAG) || (st == ST_RET);
        redir_o    = (st == ST_JUMP) || (st == ST_RET);
        eoi_o      = (st == ST_RET);

        spc_o   = spc_we_o   ? addr_q  : '0;
        spsw_o  = spsw_we_o  ? word_q  : '0;
        cause_o = cause_we_o ? cause_w : '0;

        if (st == ST_RET) begin
            psw_o = word_q;
            pc_o  = addr_q;
        end else begin
            psw_o = (st == ST_FLAG) ? entry_psw(word_q) : '0;
            pc_o  = (st == ST_JUMP) ? handler_w : '0;
        end
    end

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
    parameter int          SRC_W    = 6,
    parameter logic [31:0] VEC_BASE = 32'h0000_1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_i,
    input logic [SRC_W-1:0] src_i,
    input logic [31:0]      rpc_i,
    input logic [31:0]      psw_i,
    input logic             ret_i,
    input logic [31:0]      spc_i,
    input logic [31:0]      spsw_i,
    input logic             busy_o,
    input logic             spc_we_o,
    input logic [31:0]      spc_o,
    input logic             spsw_we_o,
    input logic [31:0]      spsw_o,
    input logic             cause_we_o,
    input logic [15:0]      cause_o,
    input logic             psw_we_o,
    input logic [31:0]      psw_o,
    input logic             redir_o,
    input logic [31:0]      pc_o,
    input logic             eoi_o
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !busy_o && !ret_i) |=> (busy_o && spc_we_o));

    // R3
    spc_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spc_we_o |-> (spc_o == $past(rpc_i)));

    // R4
    spsw_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spsw_we_o |-> (spsw_o == $past(psw_i, 2)));

    // R5
    cause_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we_o |-> (cause_o == 16'h0080 + 16'({$past(src_i, 3), 4'b0000})));

    // R6
    flag_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_we_o && !eoi_o) |->
            (psw_o == (($past(psw_i, 4) | 32'h0000_0020) & ~32'h0000_0040)));

    // R7
    vec_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_o && !eoi_o) |-> (pc_o == VEC_BASE + 32'({$past(src_i, 5), 4'b0000})));

    // R8
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spc_we_o, spsw_we_o, cause_we_o, psw_we_o && !eoi_o, redir_o && !eoi_o}));

    // R8
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spc_we_o |=> spsw_we_o ##1 cause_we_o ##1 (psw_we_o && !eoi_o) ##1 (redir_o && !eoi_o));

    // R10
    ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !busy_o) |=> (eoi_o && redir_o && psw_we_o && busy_o
                                && pc_o == $past(spc_i) && psw_o == $past(spsw_i)));

    // R11
    eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> $past(ret_i && !busy_o));

    // R12
    ret_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && take_i && !busy_o) |=> !spc_we_o);

endmodule

bind intr_ctx_seq intr_seq_chk #(.SRC_W(SRC_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .src_i(src_i), .rpc_i(rpc_i),
    .psw_i(psw_i), .ret_i(ret_i), .spc_i(spc_i), .spsw_i(spsw_i),
    .busy_o(busy_o), .spc_we_o(spc_we_o), .spc_o(spc_o), .spsw_we_o(spsw_we_o),
    .spsw_o(spsw_o), .cause_we_o(cause_we_o), .cause_o(cause_o),
    .psw_we_o(psw_we_o), .psw_o(psw_o), .redir_o(redir_o), .pc_o(pc_o),
    .eoi_o(eoi_o)
);

// File: tb/sim_intr_ctx_seq.sv
module sim_intr_ctx_seq;
    localparam int          SRC_W = 6;
    localparam logic [31:0] BASE  = 32'h0000_1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             take_i = 1'b0;
    logic [SRC_W-1:0] src_i = '0;
    logic [31:0]      rpc_i = '0;
    logic [31:0]      psw_i = '0;
    logic             ret_i = 1'b0;
    logic [31:0]      spc_i = '0;
    logic [31:0]      spsw_i = '0;
    logic             busy_o, spc_we_o, spsw_we_o, cause_we_o, psw_we_o, redir_o, eoi_o;
    logic [31:0]      spc_o, spsw_o, psw_o, pc_o;
    logic [15:0]      cause_o;
    logic [5:0]       stb;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    intr_ctx_seq #(.SRC_W(SRC_W), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .src_i(src_i), .rpc_i(rpc_i),
        .psw_i(psw_i), .ret_i(ret_i), .spc_i(spc_i), .spsw_i(spsw_i),
        .busy_o(busy_o), .spc_we_o(spc_we_o), .spc_o(spc_o), .spsw_we_o(spsw_we_o),
        .spsw_o(spsw_o), .cause_we_o(cause_we_o), .cause_o(cause_o),
        .psw_we_o(psw_we_o), .psw_o(psw_o), .redir_o(redir_o), .pc_o(pc_o),
        .eoi_o(eoi_o)
    );

    assign stb = {spc_we_o, spsw_we_o, cause_we_o, psw_we_o, redir_o, eoi_o};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " strobes"}, 32'(stb), 32'd0);
        chk({tag, " busy"}, 32'(busy_o), 32'd0);
    endtask

    // Entry sequence; optional stray strobes in the second cycle (R9, R11).
    task automatic run_entry(input logic [SRC_W-1:0] s, input logic [31:0] rpc,
                             input logic [31:0] psw, input bit poke_take, input bit poke_ret);
        logic [31:0] exp_psw;
        exp_psw = (psw | 32'h20) & ~32'h40;
        @(negedge clk);
        take_i = 1'b1; src_i = s; rpc_i = rpc; psw_i = psw;
        @(negedge clk);
        take_i = 1'b0; src_i = ~s; rpc_i = ~rpc; psw_i = ~psw;
        for (int k = 1; k <= 5; k++) begin
            chk("R2 busy in sequence", 32'(busy_o), 32'd1);
            case (k)
                1: begin
                    chk("R8 step1 strobes", 32'(stb), 32'b100000);
                    chk("R3 saved pc", spc_o, rpc);
                end
                2: begin
                    chk("R8 step2 strobes", 32'(stb), 32'b010000);
                    chk("R4 saved psw", spsw_o, psw);
                end
                3: begin
                    chk("R8 step3 strobes", 32'(stb), 32'b001000);
                    chk("R5 cause low half", 32'(cause_o), 32'(16'h0080 + 16'(s) * 16'd16));
                end
                4: begin
                    chk("R8 step4 strobes", 32'(stb), 32'b000100);
                    chk("R6 psw flags", psw_o, exp_psw);
                end
                default: begin
                    chk("R8 step5 strobes", 32'(stb), 32'b000010);
                    chk("R7 handler", pc_o, BASE + 32'(s) * 32'd16);
                end
            endcase
            if (k == 2) begin
                take_i = poke_take; ret_i = poke_ret;
                src_i = s + 1'b1; spc_i = 32'hDEAD_0000;
            end
            @(negedge clk);
            take_i = 1'b0; ret_i = 1'b0;
        end
        chk_idle("R2 after sequence");
        @(negedge clk);
        chk_idle("R9 R11 no late start");
    endtask

    task automatic run_ret(input logic [31:0] spc, input logic [31:0] spsw, input bit with_take);
        @(negedge clk);
        ret_i = 1'b1; take_i = with_take; spc_i = spc; spsw_i = spsw;
        src_i = 6'd9; rpc_i = 32'h7777_0000; psw_i = 32'h0;
        @(negedge clk);
        ret_i = 1'b0; take_i = 1'b0; spc_i = ~spc; spsw_i = ~spsw;
        chk("R10 return strobes", 32'(stb), 32'b000111);
        chk("R10 return pc", pc_o, spc);
        chk("R10 return psw", psw_o, spsw);
        chk("R10 busy in return", 32'(busy_o), 32'd1);
        @(negedge clk);
        chk_idle("R10 after return");
        @(negedge clk);
        chk_idle("R12 take dropped");
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_idle("R1 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
    endtask

    initial begin
        t_reset();
        run_entry(6'd0, 32'h0000_4A10, 32'h0000_0040, 1'b0, 1'b0);
        run_entry(6'd5, 32'h8000_0102, 32'hFFFF_FF9F, 1'b0, 1'b0);
        run_entry(6'd63, 32'h1234_5678, 32'h0000_00A0, 1'b0, 1'b0);
        run_ret(32'h0000_4A10, 32'h0000_0000, 1'b0);
        run_entry(6'd12, 32'hCAFE_0004, 32'h0000_0081, 1'b1, 1'b0);
        run_entry(6'd3, 32'h0001_0000, 32'h0000_0060, 1'b0, 1'b1);
        run_ret(32'h00AB_CDEE, 32'h0000_00C0, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule